// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table kept in memory. Pages are 1 KB. The logical address is read from the top down as a 12-bit outer index, a 10-bit inner index and a 10-bit page offset. The walker reads one outer entry, then one inner entry, and returns the physical address. If an index or an entry is illegal, it returns a fault that names the cause.

The core sends logical addresses on a valid/ready request channel and collects results on a valid/ready response channel. A request is accepted only while the walker is idle. A response stays on the port, unchanged, until the core raises rsp_ready. Toward memory the walker has a read port. It holds a read request and its address until mem_req_ready is sampled high. It then waits for exactly one mem_rsp_valid beat before it may issue anything else. That port has no ready, so the walker must accept a response beat in the cycle it comes.

Two plain control inputs set the walk: the byte address of the outer table, and the number of legal outer entries. Both are sampled when a request is accepted. Every table entry is 32 bits. Bit 0 is the valid flag. Bits 31:10 hold either the 1 KB-aligned base of the inner table or the frame number. Bits 9:1 are ignored.

Top module: `pt_walker`

## Requirements
- R1: During reset and right after it, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: The first memory read of a walk goes to tbl_base + 4 * vaddr[31:20], with tbl_base and the index taken at acceptance and the sum wrapping modulo 2^32.
- R3: After a valid outer entry E, the second read goes to {E[31:10], 10'b0} + 4 * vaddr[19:10].
- R4: After a valid inner entry F, the response has rsp_fault = 0 and rsp_paddr = {F[31:10], vaddr[9:0]}.
- R5: If vaddr[31:20] >= tbl_len at acceptance, the response is a fault with rsp_cause = 0, rsp_paddr = 0, and no memory read is made.
- R6: If the outer entry has bit 0 = 0, the response is a fault with rsp_cause = 1, rsp_paddr = 0, and no second read is made.
- R7: If the inner entry has bit 0 = 0, the response is a fault with rsp_cause = 2 and rsp_paddr = 0.
- R8: At most one memory read is outstanding. After a read handshake, mem_req_valid stays low until the matching mem_rsp_valid beat. A walk makes at most two reads.
- R9: While mem_req_ready is low, mem_req_valid and mem_req_addr hold. While rsp_ready is low, rsp_valid and the whole response payload hold. No request is accepted until the current response has been taken.
- R10: The length bound is exact. An outer index of tbl_len-1 is walked, an index equal to tbl_len faults, and tbl_len = 0 faults every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 32 | Byte address of the outer table |
| tbl_len | input | 13 | Count of legal outer entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Core takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Result is a fault |
| rsp_cause | output | 2 | Fault cause: 0 length, 1 outer invalid, 2 inner invalid |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The assertions check the handshake rules on every cycle. A stalled memory read keeps its address. A stalled response keeps its payload. A read handshake is always followed by a cycle with no request. A length fault shows up in the cycle after acceptance. A successful result only follows a memory beat. The bench scenarios cover what needs a model of table contents. These are the outer and inner read addresses, the frame-plus-offset result, the choice of fault cause, and the number of reads per walk. Those scenarios also cover the exact length boundary and the way changing the inputs after acceptance has no effect.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_OUTER,
    S_WAIT_OUTER,
    S_RD_INNER,
    S_WAIT_INNER,
    S_DONE,
    S_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_LEN   = 2'd0,
    CAUSE_OUTER = 2'd1,
    CAUSE_INNER = 2'd2
  } fault_cause_e;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10,
  parameter int LEN_W   = OUTER_W + 1,
  localparam int VA_W   = OUTER_W + INNER_W + OFF_W
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [LEN_W-1:0]   tbl_len,
  output logic [OUTER_W-1:0] oidx,
  output logic [INNER_W-1:0] iidx,
  output logic [OFF_W-1:0]   off,
  output logic               len_bad
);

  assign oidx    = vaddr[VA_W-1 -: OUTER_W];
  assign iidx    = vaddr[OFF_W +: INNER_W];
  assign off     = vaddr[OFF_W-1:0];
  assign len_bad = (LEN_W'(oidx) >= tbl_len);

endmodule

// File: rtl/pt_slot_addr.sv
module pt_slot_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int SH     = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);

  assign addr = base + (ADDR_W'(idx) << SH);

endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 10
) (
  input  logic [DATA_W-1:0] entry,
  output logic              valid,
  output logic [DATA_W-1:0] base
);

  logic unused_attr;

  assign valid       = entry[0];
  assign base        = {entry[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign unused_attr = ^entry[OFF_W-1:1];

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               len_bad,
  input  logic [INNER_W-1:0] iidx_in,
  input  logic [OFF_W-1:0]   off_in,
  input  logic [ADDR_W-1:0]  outer_addr,
  input  logic [ADDR_W-1:0]  inner_addr,
  output logic [INNER_W-1:0] iidx_q,
  input  logic               pte_valid,
  input  logic [ADDR_W-1:0]  pte_base,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [ADDR_W-1:0]  rsp_paddr
);

  walk_state_e  state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [OFF_W-1:0]  off_q;
  fault_cause_e      cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      paddr_q <= '0;
      off_q   <= '0;
      iidx_q  <= '0;
      cause_q <= CAUSE_LEN;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            iidx_q <= iidx_in;
            off_q  <= off_in;
            if (len_bad) begin
              cause_q <= CAUSE_LEN;
              paddr_q <= '0;
              state_q <= S_FAULT;
            end else begin
              addr_q  <= outer_addr;
              state_q <= S_RD_OUTER;
            end
          end
        end
        S_RD_OUTER: if (mem_req_ready) state_q <= S_WAIT_OUTER;
        S_WAIT_OUTER: begin
          if (mem_rsp_valid) begin
            if (!pte_valid) begin
              cause_q <= CAUSE_OUTER;
              paddr_q <= '0;
              state_q <= S_FAULT;
            end else begin
              addr_q  <= inner_addr;
              state_q <= S_RD_INNER;
            end
          end
        end
        S_RD_INNER: if (mem_req_ready) state_q <= S_WAIT_INNER;
        S_WAIT_INNER: begin
          if (mem_rsp_valid) begin
            if (!pte_valid) begin
              cause_q <= CAUSE_INNER;
              paddr_q <= '0;
              state_q <= S_FAULT;
            end else begin
              paddr_q <= pte_base | {{(ADDR_W-OFF_W){1'b0}}, off_q};
              state_q <= S_DONE;
            end
          end
        end
        S_DONE, S_FAULT: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_RD_OUTER) || (state_q == S_RD_INNER);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state_q == S_DONE) || (state_q == S_FAULT);
  assign rsp_fault     = (state_q == S_FAULT);
  assign rsp_cause     = cause_q;
  assign rsp_paddr     = paddr_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_fault) && $stable(rsp_cause));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OUTER_W = 12,
  parameter int INNER_W = 10,
  parameter int OFF_W   = 10,
  parameter int DATA_W  = 32,
  localparam int VA_W   = OUTER_W + INNER_W + OFF_W,
  localparam int LEN_W  = OUTER_W + 1,
  localparam int ADDR_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int SH = $clog2(DATA_W / 8);

  logic [OUTER_W-1:0] oidx;
  logic [INNER_W-1:0] iidx;
  logic [INNER_W-1:0] iidx_q;
  logic [OFF_W-1:0]   off;
  logic               len_bad;
  logic [ADDR_W-1:0]  outer_addr;
  logic [ADDR_W-1:0]  inner_addr;
  logic               pte_valid;
  logic [ADDR_W-1:0]  pte_base;

  pt_va_split #(.OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_split (
    .vaddr(req_vaddr), .tbl_len(tbl_len),
    .oidx(oidx), .iidx(iidx), .off(off), .len_bad(len_bad)
  );

  pt_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(OUTER_W), .SH(SH)) u_outer_slot (
    .base(tbl_base), .idx(oidx), .addr(outer_addr)
  );

  pt_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(INNER_W), .SH(SH)) u_inner_slot (
    .base(pte_base), .idx(iidx_q), .addr(inner_addr)
  );

  pt_pte_decode #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_decode (
    .entry(mem_rsp_data), .valid(pte_valid), .base(pte_base)
  );

  pt_walk_fsm #(.ADDR_W(ADDR_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .len_bad(len_bad), .iidx_in(iidx), .off_in(off),
    .outer_addr(outer_addr), .inner_addr(inner_addr), .iidx_q(iidx_q),
    .pte_valid(pte_valid), .pte_base(pte_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  // R5
  len_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && len_bad |=> rsp_valid && rsp_fault && (rsp_cause == 2'd0));

  // R4
  ok_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_fault |-> $past(mem_rsp_valid));

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [12:0] tbl_len = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [4];
  int mem_ready_pct = 70;
  int lat_max = 2;
  int rsp_ready_pct = 50;
  logic [31:0] salt = 32'h1234_5678;
  logic [31:0] ov_a [2];
  logic [31:0] ov_d [2];
  bit          ov_en [2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    logic [31:0] h;
    if (ov_en[0] && a == ov_a[0]) return ov_d[0];
    if (ov_en[1] && a == ov_a[1]) return ov_d[1];
    h = (a ^ salt) * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EB_CA6B;
    h = h ^ (h >> 13);
    return {h[31:1], (h[7:4] != 4'h0)};
  endfunction

  // memory model: accepts reads, answers after a random delay
  initial begin
    bit last_v = 0, last_r = 0, busy = 0;
    logic [31:0] last_a = '0, pend_a = '0;
    int cnt = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!rst_n) begin
        last_v = 0; last_r = 0; busy = 0;
        continue;
      end
      if (mem_req_valid && busy) chk(0, "R8", "read issued while one outstanding", 32'd1, 32'd0);
      if (last_v && last_r) begin
        chk(!busy, "R8", "handshake while outstanding", {31'd0, busy}, 32'd0);
        if (rd_cnt < 4) rd_addr[rd_cnt] = last_a;
        rd_cnt++;
        busy = 1;
        cnt = $urandom_range(lat_max, 0);
        pend_a = last_a;
      end else if (last_v && !last_r) begin
        chk(mem_req_valid && mem_req_addr == last_a, "R9", "stalled read changed",
            mem_req_addr, last_a);
      end
      if (busy) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_fn(pend_a);
          busy = 0;
        end else cnt--;
      end
      mem_req_ready = ($urandom_range(99, 0) < mem_ready_pct);
      last_v = mem_req_valid;
      last_r = mem_req_ready;
      last_a = mem_req_addr;
    end
  end

  task automatic ref_walk(input logic [31:0] va, input logic [31:0] base, input logic [12:0] len,
                          output bit f, output logic [1:0] c, output logic [31:0] pa,
                          output int n, output logic [31:0] a1, output logic [31:0] a2);
    logic [31:0] e1, e2;
    f = 0; c = 0; pa = 0; n = 0; a1 = 0; a2 = 0;
    if ({1'b0, va[31:20]} >= len) begin f = 1; c = 0; return; end
    a1 = base + {18'd0, va[31:20], 2'b00};
    n = 1;
    e1 = mem_fn(a1);
    if (!e1[0]) begin f = 1; c = 1; return; end
    a2 = {e1[31:10], 10'd0} + {20'd0, va[19:10], 2'b00};
    n = 2;
    e2 = mem_fn(a2);
    if (!e2[0]) begin f = 1; c = 2; return; end
    pa = {e2[31:10], va[9:0]};
  endtask

  task automatic do_walk(input logic [31:0] va, input string len_tag);
    bit ef; logic [1:0] ec; logic [31:0] epa, ea1, ea2; int en;
    bit got = 0, prev_hold = 0;
    logic [31:0] p_pa; bit p_f; logic [1:0] p_c;
    bit g_f = 0; logic [1:0] g_c = 0; logic [31:0] g_pa = 0;
    string tag;
    ref_walk(va, tbl_base, tbl_len, ef, ec, epa, en, ea1, ea2);
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom;
    tbl_base  = $urandom;
    while (!got) begin
      if (prev_hold)
        chk(rsp_valid && rsp_paddr == p_pa && rsp_fault == p_f && rsp_cause == p_c,
            "R9", "stalled response changed", rsp_paddr, p_pa);
      rsp_ready = ($urandom_range(99, 0) < rsp_ready_pct);
      if (rsp_valid && rsp_ready) begin
        got = 1; g_f = rsp_fault; g_c = rsp_cause; g_pa = rsp_paddr;
      end
      prev_hold = rsp_valid && !rsp_ready;
      p_pa = rsp_paddr; p_f = rsp_fault; p_c = rsp_cause;
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    if (!ef) tag = "R4";
    else if (ec == 2'd0) tag = len_tag;
    else if (ec == 2'd1) tag = "R6";
    else tag = "R7";
    chk(g_f == ef, tag, "fault flag", {31'd0, g_f}, {31'd0, ef});
    chk(g_c == ec || !ef, tag, "fault cause", {30'd0, g_c}, {30'd0, ec});
    chk(g_pa == epa, tag, "physical address", g_pa, epa);
    chk(rd_cnt == en, (en == 0) ? len_tag : "R8", "read count", rd_cnt, en);
    if (en >= 1) chk(rd_addr[0] == ea1, "R2", "outer read address", rd_addr[0], ea1);
    if (en >= 2) chk(rd_addr[1] == ea2, "R3", "inner read address", rd_addr[1], ea2);
  endtask

  // force both entries on the walk of va: outer ok?, inner ok?
  task automatic set_chain(input logic [31:0] va, input bit o_ok, input bit i_ok);
    logic [21:0] tbase, frame;
    tbase = $urandom;
    frame = $urandom;
    ov_a[0] = tbl_base + {18'd0, va[31:20], 2'b00};
    ov_d[0] = {tbase, 9'h1A5, o_ok};
    ov_a[1] = {tbase, 10'd0} + {20'd0, va[19:10], 2'b00};
    ov_d[1] = {frame, 9'h0F3, i_ok};
    ov_en[0] = 1; ov_en[1] = 1;
  endtask

  task automatic set_ctl(input logic [31:0] b, input logic [12:0] l);
    @(negedge clk);
    tbl_base = b;
    tbl_len  = l;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog expired actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] va;
    void'($urandom(32'd20240611));
    ov_en[0] = 0; ov_en[1] = 0;
    ov_a[0] = '0; ov_a[1] = '0; ov_d[0] = '0; ov_d[1] = '0;
    rd_addr[0] = '0; rd_addr[1] = '0; rd_addr[2] = '0; rd_addr[3] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1",
        "idle after reset", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

    // R10: empty table faults every address
    set_ctl(32'h0001_0000, 13'd0);
    do_walk(32'h0000_0000, "R10");
    // R10: last legal index walks, first illegal one faults
    set_ctl(32'h0002_0000, 13'd5);
    va = {12'd4, 10'h155, 10'h2AB};
    set_chain(va, 1, 1);
    do_walk(va, "R10");
    set_ctl(32'h0002_0000, 13'd5);
    do_walk({12'd5, 10'h001, 10'h3FF}, "R10");
    // R5: index far beyond the bound
    set_ctl(32'h0002_0000, 13'd5);
    do_walk({12'hFFF, 20'h12345}, "R5");
    // R4: highest index with full table, ignored bits set in entries
    set_ctl(32'hFFFF_F000, 13'd4096);
    va = {12'hFFF, 10'h3FF, 10'h000};
    set_chain(va, 1, 1);
    do_walk(va, "R10");
    // R6: invalid outer entry
    set_ctl(32'h0040_0000, 13'd4096);
    va = 32'h1234_5678;
    set_chain(va, 0, 1);
    do_walk(va, "R5");
    // R7: invalid inner entry
    set_ctl(32'h0040_0000, 13'd4096);
    va = 32'h89AB_CDEF;
    set_chain(va, 1, 0);
    do_walk(va, "R5");
    ov_en[0] = 0; ov_en[1] = 0;

    // random walks over hashed table contents
    for (int i = 0; i < 160; i++) begin
      if (i % 40 == 0) begin
        salt = $urandom;
        lat_max = $urandom_range(3, 0);
        mem_ready_pct = $urandom_range(90, 30);
        rsp_ready_pct = $urandom_range(90, 30);
      end
      set_ctl($urandom, ($urandom_range(9, 0) < 7) ? 13'd4096 : 13'($urandom_range(4096, 1)));
      do_walk($urandom, "R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule